// File: doc/BRIEF.md
# Network loop code detector

This block watches the recovered receive bit stream, one bit per receive clock, for the two repeating in-band maintenance codes. The loop-up code is a remote terminal's request to loop the line back. The loop-down code asks for that loop to be removed. The stream is cut into fixed windows of `WIN_BITS` bits, counted from reset release. At the close of each window the block asks whether the bits matched a repeating code at any phase alignment, allowing a few bit errors. A status flag is raised only after the code has held for longer than a programmed persistence period, given in receive-clock cycles. The flag falls again at the first window that does not match.

A two-bit enable field selects the mode. Detection can be off, it can look for loop-up only, or for loop-down only. The fourth value is automatic mode, which watches for both codes and drives a remote-loopback request. That request is raised when loop-up is confirmed and dropped when loop-down is confirmed. While the local transmitter is sending its own loop-up code, automatic loop-up detection is held off. This keeps the far end's answer to a local request from starting a loopback here. The loopback datapath itself lies outside this block.

Top module: `loop_code_detector`

## Requirements
- R1: The loop-up code is the bit sequence 0,0,0,0,1 in time order, repeating. A window of `WIN_BITS` received bits matches when, for at least one of the 5 phase alignments, at most `MAX_ERR` bits differ from it.
- R2: The loop-down code is the bit sequence 0,0,1 in time order, repeating. It is judged per window in the same way, over its 3 phase alignments.
- R3: Windows are counted from the first clock edge after reset release. A flag is set at the clock edge that closes the N-th consecutive matching window, where N = `PERSIST_CYC`/`WIN_BITS` + 1. With `WIN_BITS`=40 and `PERSIST_CYC`=200 this is the edge that samples bit 240.
- R4: A window that fails to match restarts the persistence count. A window with `MAX_ERR` errors still counts as a match.
- R5: A set flag clears at the edge that closes the first window in which its code fails to match.
- R6: Enable value 00 turns detection off. Both flags read 0 from the next edge on.
- R7: Enable value 01 detects loop-up only, and the loop-down flag stays 0. Enable value 10 detects loop-down only, and the loop-up flag stays 0.
- R8: Enable value 11 detects both codes. The remote-loopback request rises at the edge where the loop-up flag is set. It stays high until the edge where the loop-down flag is set, even after loop-up goes away. It is 0 whenever the enable field is not 11.
- R9: In enable mode 11, while the local loop-up-transmit input is high, loop-up persistence is held at zero, the loop-up flag stays 0 and the remote-loopback request cannot rise. This also applies when that input rises in the very cycle that would complete persistence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered receive clock; one data bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Recovered receive data bit |
| det_en | input | 2 | 00 off, 01 loop-up only, 10 loop-down only, 11 automatic |
| tx_loopup_active | input | 1 | High while the local transmitter sends loop-up code |
| loopup_det | output | 1 | Loop-up code confirmed |
| loopdown_det | output | 1 | Loop-down code confirmed |
| remote_lb | output | 1 | Remote-loopback request (automatic mode) |

## Verification
Two functions can land in the same cycle. Loop-up persistence can complete on the same edge at which the local loop-up-transmit input rises. The bench drives that input high together with bit 240 of a clean loop-up stream in automatic mode, so the window close and the suppression coincide. It then checks that neither the loop-up flag nor the remote-loopback request rises on that edge, or in the hundreds of bits that follow. A second scenario checks a release edge in automatic mode: the request falls exactly at the edge that confirms loop-down, and holds one bit earlier.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

  typedef enum logic [1:0] {
    DET_OFF  = 2'b00,
    DET_UP   = 2'b01,
    DET_DOWN = 2'b10,
    DET_AUTO = 2'b11
  } det_mode_e;

  // Number of consecutive matching windows that cover strictly more than
  // the persistence period.
  function automatic int need_windows(input int persist_cyc, input int win_bits);
    return persist_cyc / win_bits + 1;
  endfunction

  // Pattern index expected at position pos when aligned at phase ofs.
  function automatic int wrap_idx(input int pos, input int ofs, input int plen);
    return (pos + ofs) % plen;
  endfunction

endpackage

// File: rtl/lcd_window_timer.sv
module lcd_window_timer #(
  parameter int WIN_BITS = 40
) (
  input  logic clk,
  input  logic rst_n,
  output logic win_last
);
  localparam int WW = $clog2(WIN_BITS);
  localparam logic [WW-1:0] LAST = WW'(WIN_BITS - 1);

  logic [WW-1:0] wpos;

  always_ff @(posedge clk) begin
    if (!rst_n)            wpos <= '0;
    else if (wpos == LAST) wpos <= '0;
    else                   wpos <= wpos + 1'b1;
  end

  assign win_last = (wpos == LAST);

  // R3: window position never leaves its range
  assert_wpos_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wpos <= LAST);

  // R3: a window close is followed by a fresh window
  assert_window_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    win_last |=> !win_last);

endmodule

// File: rtl/lcd_phase_matcher.sv
module lcd_phase_matcher #(
  parameter int              PLEN     = 5,
  parameter logic [PLEN-1:0] PATTERN  = '0,
  parameter int              WIN_BITS = 40,
  parameter int              MAX_ERR  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_bit,
  input  logic win_last,
  output logic win_match
);
  localparam int EW = $clog2(WIN_BITS + 1);
  localparam int PW = $clog2(PLEN);
  localparam logic [EW-1:0] MAX_E = EW'(MAX_ERR);
  localparam logic [PW-1:0] PLAST = PW'(PLEN - 1);

  logic [PW-1:0]   pos;
  logic [PLEN-1:0] phase_ok;

  always_ff @(posedge clk) begin
    if (!rst_n)             pos <= '0;
    else if (pos == PLAST)  pos <= '0;
    else                    pos <= pos + 1'b1;
  end

  for (genvar p = 0; p < PLEN; p++) begin : g_phase
    logic [EW-1:0] err_cnt;
    logic [EW-1:0] tally;
    logic [PW-1:0] exp_idx;
    logic          miss;

    assign exp_idx = PW'(lcd_pkg::wrap_idx(int'(pos), p, PLEN));
    assign miss    = rx_bit ^ PATTERN[exp_idx];
    assign tally   = err_cnt + EW'(miss);
    assign phase_ok[p] = (tally <= MAX_E);

    always_ff @(posedge clk) begin
      if (!rst_n)        err_cnt <= '0;
      else if (win_last) err_cnt <= '0;
      else               err_cnt <= tally;
    end

    // R1: per-phase error tally only resets at window close
    assert_err_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      win_last |=> (err_cnt == '0));
  end

  assign win_match = |phase_ok;

endmodule

// File: rtl/lcd_persist.sv
module lcd_persist #(
  parameter int NEED = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic win_last,
  input  logic win_match,
  output logic flag,
  output logic set_evt
);
  localparam int CW = $clog2(NEED + 1);
  localparam logic [CW-1:0] NEED_C = CW'(NEED);

  logic [CW-1:0] run_cnt;
  logic          fail_evt;

  assign set_evt  = enable && win_last && win_match && (run_cnt == NEED_C - 1'b1);
  assign fail_evt = enable && win_last && !win_match;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      run_cnt <= '0;
      flag    <= 1'b0;
    end else if (win_last) begin
      if (win_match) begin
        if (run_cnt != NEED_C) run_cnt <= run_cnt + 1'b1;
        if (set_evt)           flag    <= 1'b1;
      end else begin
        run_cnt <= '0;
        flag    <= 1'b0;
      end
    end
  end

  // R3: a flag only rises at the close of a matching window
  assert_rise_on_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(set_evt));

  // R5: a failed window leaves the flag low
  assert_fail_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fail_evt |=> !flag);

  // R6: a disabled detector reports nothing
  assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !flag);

  // R4: run counter saturates
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= NEED_C);

endmodule

// File: rtl/lcd_remote_ctl.sv
module lcd_remote_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_mode,
  input  logic tx_loopup_active,
  input  logic up_set_evt,
  input  logic down_set_evt,
  output logic remote_lb
);
  always_ff @(posedge clk) begin
    if (!rst_n || !auto_mode)          remote_lb <= 1'b0;
    else if (down_set_evt)             remote_lb <= 1'b0;
    else if (up_set_evt && !tx_loopup_active) remote_lb <= 1'b1;
  end

  // R8: request only exists in automatic mode
  assert_auto_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_mode |=> !remote_lb);

  // R8: loop-down confirmation releases the request
  assert_down_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    down_set_evt |=> !remote_lb);

  // R9: local loop-up transmission blocks activation
  assert_tx_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_loopup_active |=> !$rose(remote_lb));

endmodule

// File: rtl/loop_code_detector.sv
module loop_code_detector #(
  parameter int WIN_BITS    = 40,
  parameter int MAX_ERR     = 2,
  parameter int PERSIST_CYC = 7720000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_bit,
  input  logic [1:0] det_en,
  input  logic       tx_loopup_active,
  output logic       loopup_det,
  output logic       loopdown_det,
  output logic       remote_lb
);
  import lcd_pkg::*;

  localparam int NEED = need_windows(PERSIST_CYC, WIN_BITS);

  det_mode_e mode;
  logic      win_last;
  logic      up_match, down_match;
  logic      up_enable, down_enable;
  logic      up_set_evt, down_set_evt;
  logic      auto_mode;

  assign mode        = det_mode_e'(det_en);
  assign auto_mode   = (mode == DET_AUTO);
  assign up_enable   = (mode == DET_UP) || (auto_mode && !tx_loopup_active);
  assign down_enable = (mode == DET_DOWN) || auto_mode;

  lcd_window_timer #(.WIN_BITS(WIN_BITS)) u_win (
    .clk(clk), .rst_n(rst_n), .win_last(win_last)
  );

  lcd_phase_matcher #(.PLEN(5), .PATTERN(5'b10000), .WIN_BITS(WIN_BITS),
                      .MAX_ERR(MAX_ERR)) u_up_match (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .win_last(win_last),
    .win_match(up_match)
  );

  lcd_phase_matcher #(.PLEN(3), .PATTERN(3'b100), .WIN_BITS(WIN_BITS),
                      .MAX_ERR(MAX_ERR)) u_down_match (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .win_last(win_last),
    .win_match(down_match)
  );

  lcd_persist #(.NEED(NEED)) u_up_persist (
    .clk(clk), .rst_n(rst_n), .enable(up_enable), .win_last(win_last),
    .win_match(up_match), .flag(loopup_det), .set_evt(up_set_evt)
  );

  lcd_persist #(.NEED(NEED)) u_down_persist (
    .clk(clk), .rst_n(rst_n), .enable(down_enable), .win_last(win_last),
    .win_match(down_match), .flag(loopdown_det), .set_evt(down_set_evt)
  );

  lcd_remote_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode),
    .tx_loopup_active(tx_loopup_active), .up_set_evt(up_set_evt),
    .down_set_evt(down_set_evt), .remote_lb(remote_lb)
  );

  // R7: single-code modes keep the other flag low
  assert_up_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == DET_UP) |=> !loopdown_det);
  assert_down_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == DET_DOWN) |=> !loopup_det);

  // R8: request rises together with loop-up confirmation
  assert_lb_follows_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(remote_lb) |-> $rose(loopup_det));

  // R9: no loop-up flag while local loop-up is sent in automatic mode
  assert_up_suppressed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_mode && tx_loopup_active) |=> !loopup_det);

endmodule

// File: tb/sim_loop_code_detector.sv
`timescale 1ns/1ps
module sim_loop_code_detector;
  localparam int WB = 40;
  localparam int NEED_BITS = (200 / WB + 1) * WB;  // 240

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_bit = 1'b0;
  logic [1:0] det_en = 2'b00;
  logic       tx_loopup_active = 1'b0;
  logic       loopup_det, loopdown_det, remote_lb;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  loop_code_detector #(.WIN_BITS(WB), .MAX_ERR(2), .PERSIST_CYC(200)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .det_en(det_en),
    .tx_loopup_active(tx_loopup_active), .loopup_det(loopup_det),
    .loopdown_det(loopdown_det), .remote_lb(remote_lb)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // kind 0: zeros, 1: loop-up, 2: loop-down, 3: ones
  function automatic logic pat(input int kind, input int i);
    case (kind)
      1: return (i % 5) == 4;
      2: return (i % 3) == 2;
      3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Sends bits [start, start+n) of a stream; errs flips per window at
  // offsets 0,10,20; window bad_win gets 3 flips.
  task automatic send(input int kind, input int start, input int n,
                      input int errs, input int bad_win);
    for (int i = start; i < start + n; i++) begin
      int k = i % WB;
      int ne = ((i / WB) == bad_win) ? 3 : errs;
      logic b = pat(kind, i);
      if ((k % 10) == 0 && (k / 10) < ne) b = ~b;
      rx_bit = b;
      @(posedge clk);
      #1;
    end
  endtask

  task automatic do_reset(input logic [1:0] en);
    rst_n = 1'b0;
    det_en = en;
    tx_loopup_active = 1'b0;
    rx_bit = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
  endtask

  task automatic t_reset;
    do_reset(2'b11);
    check("R6 reset up", loopup_det, 1'b0);
    check("R6 reset down", loopdown_det, 1'b0);
    check("R8 reset lb", remote_lb, 1'b0);
  endtask

  task automatic t_up_persist;
    do_reset(2'b01);
    send(1, 0, NEED_BITS - 1, 0, -1);
    check("R3 up before period", loopup_det, 1'b0);
    send(1, NEED_BITS - 1, 1, 0, -1);
    check("R1 R3 up at period", loopup_det, 1'b1);
    send(0, 0, 39, 0, -1);
    check("R5 up held in window", loopup_det, 1'b1);
    send(0, 39, 1, 0, -1);
    check("R5 up cleared", loopup_det, 1'b0);
  endtask

  task automatic t_up_errors;
    do_reset(2'b01);
    send(1, 0, NEED_BITS, 2, -1);
    check("R4 two errors tolerated", loopup_det, 1'b1);
    do_reset(2'b01);
    send(1, 0, 359, 0, 2);
    check("R4 restart after bad window", loopup_det, 1'b0);
    send(1, 359, 1, 0, -1);
    check("R4 set after restart", loopup_det, 1'b1);
  endtask

  task automatic t_modes;
    do_reset(2'b01);
    send(2, 0, 300, 0, -1);
    check("R7 down ignored in up mode", loopdown_det, 1'b0);
    check("R1 down stream not loop-up", loopup_det, 1'b0);
    do_reset(2'b01);
    send(3, 0, 300, 0, -1);
    check("R1 ones not loop-up", loopup_det, 1'b0);
    do_reset(2'b10);
    send(1, 0, 300, 0, -1);
    check("R7 up ignored in down mode", loopup_det, 1'b0);
    check("R2 up stream not loop-down", loopdown_det, 1'b0);
    do_reset(2'b10);
    send(2, 0, NEED_BITS - 1, 1, -1);
    check("R2 down before period", loopdown_det, 1'b0);
    send(2, NEED_BITS - 1, 1, 1, -1);
    check("R2 down at period", loopdown_det, 1'b1);
  endtask

  task automatic t_off;
    do_reset(2'b01);
    send(1, 0, NEED_BITS, 0, -1);
    check("R6 flag up before off", loopup_det, 1'b1);
    det_en = 2'b00;
    send(1, NEED_BITS, 1, 0, -1);
    check("R6 off clears up", loopup_det, 1'b0);
    send(1, NEED_BITS + 1, 300, 0, -1);
    check("R6 off stays clear", loopup_det, 1'b0);
    check("R8 off no lb", remote_lb, 1'b0);
  endtask

  task automatic t_auto;
    do_reset(2'b11);
    send(1, 0, NEED_BITS - 1, 0, -1);
    check("R8 lb before period", remote_lb, 1'b0);
    send(1, NEED_BITS - 1, 41, 0, -1);
    check("R8 lb set", remote_lb, 1'b1);
    check("R8 up flag set", loopup_det, 1'b1);
    // loop-down from bit 280 (window 8 onward); confirmed at bit 520
    send(2, 280, 120, 0, -1);
    check("R8 lb held after up gone", remote_lb, 1'b1);
    check("R5 up cleared in auto", loopup_det, 1'b0);
    send(2, 400, 119, 0, -1);
    check("R8 lb held before down period", remote_lb, 1'b1);
    send(2, 519, 1, 0, -1);
    check("R8 lb released", remote_lb, 1'b0);
    check("R8 down flag set", loopdown_det, 1'b1);
    det_en = 2'b01;
    send(2, 520, 1, 0, -1);
    check("R7 down cleared leaving auto", loopdown_det, 1'b0);
  endtask

  task automatic t_tx_race;
    do_reset(2'b11);
    send(1, 0, NEED_BITS - 1, 0, -1);
    tx_loopup_active = 1'b1;
    send(1, NEED_BITS - 1, 1, 0, -1);
    check("R9 up blocked at completion", loopup_det, 1'b0);
    check("R9 lb blocked at completion", remote_lb, 1'b0);
    send(1, NEED_BITS, 300, 0, -1);
    check("R9 up blocked while tx", loopup_det, 1'b0);
    check("R9 lb blocked while tx", remote_lb, 1'b0);
    tx_loopup_active = 1'b0;
    send(1, NEED_BITS + 300, NEED_BITS, 0, -1);
    check("R9 up after tx drops", loopup_det, 1'b1);
  endtask

  initial begin
    t_reset();
    t_up_persist();
    t_up_errors();
    t_modes();
    t_off();
    t_auto();
    t_tx_race();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule